// File: doc/BRIEF.md
# Strided Region Address Sequencer

This block produces the sequence of 64-bit beat addresses that a memory test visits. Four configuration words set the walk: a first address, an exclusive upper bound, a region length and a stride. The sequencer covers one region beat by beat, eight bytes at a time. It then moves the region base forward by the stride and covers the next region. It keeps going until the next base reaches the bound.

A controller pulses `start_i` to launch or relaunch a run. It takes each address through a valid/advance handshake. It uses `last_o` to see the final beat of a pass, which is where it switches from writing to reading. After the final beat is accepted, `done_o` rises and stays high until the next start. Overlapping regions are allowed, which happens when the stride is smaller than the region length. Data generation and comparison belong to the controller.

Top module: `strd_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `done_o` are all low until the first start pulse.
- R2: The cycle after a start pulse that launches a run, `valid_o` is high and `addr_o` equals the first address. The low five bits of all four configuration words are ignored, so every value is taken as a multiple of 32.
- R3: Inside a region, each accepted advance (`valid_o` and `adv_i` both high) raises `addr_o` by 8. While `adv_i` is low, `addr_o` and `valid_o` hold.
- R4: Once a region of `size_i` bytes has been covered, the next address is the base of the region just finished plus `step_i`.
- R5: `addr_o` is always below the end bound. A region that would cross the bound is cut after the beat at end minus 8, and the walk then goes on to the next region base.
- R6: `last_o` is high only with `valid_o`, and only on the final address of the sequence.
- R7: The cycle after the final beat is accepted, `valid_o` is low and `done_o` is high. `done_o` stays high until the next start pulse.
- R8: If the region length is zero, or the first address is at or beyond the end bound, a start pulse gives `done_o` high the next cycle and no address is issued.
- R9: A stride of zero ends the sequence after the first region. A next base at or beyond the bound also ends it, and that includes a base that overflows the address width.
- R10: A start pulse in the middle of a run reloads the first address and replays the same sequence from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start/restart pulse; captures the configuration |
| start_addr_i | input | ADDR_W | First address of the walk |
| end_addr_i | input | ADDR_W | Exclusive upper bound |
| size_i | input | ADDR_W | Region length in bytes |
| step_i | input | ADDR_W | Distance between consecutive region bases |
| adv_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | `addr_o` holds a beat address |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | Current address is the final one |
| done_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with its default 32-bit address width, 8-byte beat and 32-byte alignment. It sweeps first address, bound, region length and stride over every multiple of 32 up to a few hundred bytes. That range covers overlapping, contiguous and gapped regions, cut regions, zero stride and empty runs. A stride near the top of the 32-bit range tests the wrap-around stop. Inputs with the low five bits set test the alignment rule. Restarts in the middle of a run and held advances are mixed into the sweep.

// File: rtl/strd_seq_pkg.sv
package strd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strd_offset_ctr.sv
module strd_offset_ctr #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic              wrap_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic              full_o
);
  localparam logic [ADDR_W:0] BEAT_W = (ADDR_W+1)'(BEAT_BYTES);

  logic [ADDR_W-1:0] offset_q;
  logic [ADDR_W:0]   offset_nxt;

  assign offset_nxt = {1'b0, offset_q} + BEAT_W;
  assign full_o     = (offset_nxt == {1'b0, size_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       offset_q <= '0;
    else if (clear_i)  offset_q <= '0;
    else if (adv_i)    offset_q <= wrap_i ? '0 : offset_nxt[ADDR_W-1:0];
  end
endmodule

// File: rtl/strd_cursor.sv
module strd_cursor #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              adv_i,
  input  logic              region_full_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              region_done_o,
  output logic              final_o
);
  localparam logic [ADDR_W:0] BEAT_W = (ADDR_W+1)'(BEAT_BYTES);

  logic [ADDR_W-1:0] base_q, addr_q;
  logic [ADDR_W:0]   addr_nxt, base_nxt;
  logic              end_hit, base_stop;

  // one extra bit so an overflowing sum still compares as past the bound
  assign addr_nxt      = {1'b0, addr_q} + BEAT_W;
  assign base_nxt      = {1'b0, base_q} + {1'b0, step_i};
  assign end_hit       = (addr_nxt >= {1'b0, end_i});
  assign base_stop     = (step_i == '0) || (base_nxt >= {1'b0, end_i});
  assign region_done_o = region_full_i || end_hit;
  assign final_o       = region_done_o && base_stop;
  assign addr_o        = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      base_q <= load_addr_i;
      addr_q <= load_addr_i;
    end else if (adv_i && !final_o) begin
      if (region_done_o) begin
        base_q <= base_nxt[ADDR_W-1:0];
        addr_q <= base_nxt[ADDR_W-1:0];
      end else begin
        addr_q <= addr_nxt[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/strd_seq.sv
module strd_seq
  import strd_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BEAT_BYTES  = 8,
  parameter int ALIGN_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic              adv_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(ALIGN_BYTES - 1));

  seq_state_e        state_q;
  logic [ADDR_W-1:0] start_al, end_al, size_al, step_al;
  logic [ADDR_W-1:0] cfg_end_q, cfg_size_q, cfg_step_q;
  logic              launch_ok, fire, region_full, region_done, seq_final;

  assign start_al  = start_addr_i & ALIGN_MASK;
  assign end_al    = end_addr_i   & ALIGN_MASK;
  assign size_al   = size_i       & ALIGN_MASK;
  assign step_al   = step_i       & ALIGN_MASK;
  assign launch_ok = (size_al != '0) && (start_al < end_al);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_end_q  <= '0;
      cfg_size_q <= '0;
      cfg_step_q <= '0;
    end else if (start_i) begin
      cfg_end_q  <= end_al;
      cfg_size_q <= size_al;
      cfg_step_q <= step_al;
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign fire    = valid_o && adv_i;
  assign last_o  = valid_o && seq_final;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           state_q <= ST_IDLE;
    else if (start_i)                      state_q <= launch_ok ? ST_RUN : ST_DONE;
    else if (fire && seq_final)            state_q <= ST_DONE;
  end

  strd_cursor #(
    .ADDR_W    (ADDR_W),
    .BEAT_BYTES(BEAT_BYTES)
  ) u_cursor (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start_i),
    .load_addr_i  (start_al),
    .adv_i        (fire),
    .region_full_i(region_full),
    .step_i       (cfg_step_q),
    .end_i        (cfg_end_q),
    .addr_o       (addr_o),
    .region_done_o(region_done),
    .final_o      (seq_final)
  );

  strd_offset_ctr #(
    .ADDR_W    (ADDR_W),
    .BEAT_BYTES(BEAT_BYTES)
  ) u_offset (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .adv_i  (fire),
    .wrap_i (region_done),
    .size_i (cfg_size_q),
    .full_o (region_full)
  );
endmodule

// File: rtl/strd_seq_chk.sv
module strd_seq_chk #(
  parameter int ADDR_W   = 32,
  parameter int BEAT_LSB = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              adv_i,
  input logic              valid_o,
  input logic              last_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] end_q
);
  a_r2_beat_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_o[BEAT_LSB-1:0] == '0));

  a_r3_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !adv_i && !start_i) |=> (valid_o && $stable(addr_o)));

  a_r5_below_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_o < end_q));

  a_r6_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adv_i && last_o && !start_i) |=> (done_o && !valid_o));

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r7_valid_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));
endmodule

bind strd_seq strd_seq_chk #(
  .ADDR_W  (ADDR_W),
  .BEAT_LSB($clog2(BEAT_BYTES))
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .adv_i  (adv_i),
  .valid_o(valid_o),
  .last_o (last_o),
  .done_o (done_o),
  .addr_o (addr_o),
  .end_q  (cfg_end_q)
);

// File: tb/strd_seq_bench.sv
module strd_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        adv = 1'b0;
  logic [31:0] s_addr = '0, e_addr = '0, size = '0, step = '0;
  logic        valid, last, done;
  logic [31:0] addr;

  int errors = 0;
  int checks = 0;
  int case_no = 0;
  bit finished = 1'b0;

  logic [31:0] exp_a [256];
  int          exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  strd_seq u_strd_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .start_addr_i(s_addr), .end_addr_i(e_addr), .size_i(size), .step_i(step),
    .adv_i(adv), .valid_o(valid), .addr_o(addr), .last_o(last), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s case %0d: actual=0x%0h expected=0x%0h", req, case_no, act, expv);
    end
  endtask

  // arithmetic model of the walk
  task automatic build(input longint s, input longint e, input longint sz, input longint st);
    longint base, a;
    s = s & 64'hFFFF_FFE0; e = e & 64'hFFFF_FFE0;
    sz = sz & 64'hFFFF_FFE0; st = st & 64'hFFFF_FFE0;
    exp_n = 0;
    if (sz == 0 || s >= e) return;
    base = s;
    forever begin
      for (longint off = 0; off < sz; off += 8) begin
        a = base + off;
        if (a >= e) break;
        exp_a[exp_n] = a[31:0];
        exp_n++;
      end
      if (st == 0 || base + st >= e) return;
      base = base + st;
    end
  endtask

  task automatic run_case(input logic [31:0] s, input logic [31:0] e, input logic [31:0] sz,
                          input logic [31:0] st, input bit stall, input int restart_at);
    bit restarted = 1'b0;
    int i = 0;
    string tag;
    case_no++;
    build(s, e, sz, st);
    s_addr = s; e_addr = e; size = sz; step = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_n == 0) begin
      check(done && !valid, "R8", {valid, done}, 2'b01);
      @(negedge clk);
      check(done && !valid, "R8", {valid, done}, 2'b01);
      return;
    end
    while (i < exp_n) begin
      if (restarted)                                  tag = "R10";
      else if (i == 0)                                tag = "R2";
      else if (st == 0)                               tag = "R9";
      else if (exp_a[i] == exp_a[i-1] + 32'd8)         tag = "R3";
      else                                            tag = "R4";
      check(valid && addr == exp_a[i], tag, {valid, addr}, {1'b1, exp_a[i]});
      check(addr < (e & 32'hFFFF_FFE0), "R5", addr, e & 32'hFFFF_FFE0);
      check(last == (i == exp_n - 1), "R6", last, (i == exp_n - 1));
      if (stall && (i % 3 == 1)) begin
        @(negedge clk);
        check(valid && addr == exp_a[i], "R3", addr, exp_a[i]);
      end
      if (i == restart_at && !restarted) begin
        restarted = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        i = 0;
        continue;
      end
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
      i++;
    end
    check(done && !valid, "R7", {valid, done}, 2'b01);
    @(negedge clk);
    check(done && !valid && !last, "R7", {valid, done}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!valid && !done && !last, "R1", {valid, last, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!valid && !done && !last, "R1", {valid, last, done}, 0);

    for (int si = 0; si < 3; si++)
      for (int ei = 0; ei < 9; ei++)
        for (int zi = 0; zi < 4; zi++)
          for (int ti = 0; ti < 4; ti++)
            run_case(32'(si*32), 32'(ei*32), 32'(zi*32), 32'(ti*32), (case_no % 2) == 1, -1);

    // R2: low five bits of every configuration word ignored
    run_case(32'h45, 32'h11F, 32'h3F, 32'h5B, 1'b0, -1);
    // R9: stride overflowing the address width ends the walk
    run_case(32'h40, 32'h100, 32'h20, 32'hFFFF_FFE0, 1'b0, -1);
    run_case(32'hFFFF_FF00, 32'hFFFF_FFE0, 32'h40, 32'h40, 1'b1, -1);
    // R10: restart in the middle replays the sequence
    run_case(32'h20, 32'h120, 32'h40, 32'h60, 1'b0, 5);
    run_case(32'h0, 32'hC0, 32'h60, 32'h20, 1'b1, 2);
    // R8: empty launch from a done state after a full run
    run_case(32'h80, 32'h80, 32'h20, 32'h20, 1'b0, -1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule